// File: doc/BRIEF.md
# Lane Metaframe Framing Generator

This block wraps a stream of 64-bit payload words, each carrying one control flag, into repeating per-lane metaframes of 67-bit words. Every metaframe is a fixed number of words long. It opens with three control words: a lane-alignment word, a descrambler-state word and a rate-compensation word. Payload words fill the middle. A diagnostic word, which carries a two-bit lane status, closes the frame. The scrambler state, the CRC field and the inversion bit are written as zeros, because later stages of the lane fill them in.

Both sides of the block use valid/ready streams. A word moves on a side only in a cycle where valid and ready are both high. The block holds one output word in a register. While that word is stalled (`out_valid` high, `out_ready` low), the word stays unchanged and the input is not accepted. In the cycles that emit a control word, `in_ready` is low whatever the state of the output side, so no payload word is dropped or overwritten. When the output register is empty or draining, `in_ready` follows `out_ready` in the same cycle during payload slots.

Top module: `mframe_framer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `out_valid` is 0. The first word emitted after reset is an alignment word.
- R2: The transferred words repeat in this order: alignment, descrambler-state, rate-compensation, then FRAME_LEN-4 payload words, then diagnostic. FRAME_LEN is a parameter with a minimum of 5.
- R3: Every output word has bit 66 (inversion placeholder) equal to 0. Control words carry header bits [65:64] = 2'b10. The descrambler-state word has [63:58] = 6'h0A, and the rate-compensation word has [63:58] = 6'h07. In both, [57:0] are 0.
- R4: A payload word is output as {1'b0, hdr, in_data}, where hdr is 2'b10 if `in_ctl` is 1 and 2'b01 if it is 0.
- R5: `in_ready` is 0 whenever the next slot to be filled is a control word. In a payload slot it equals (!out_valid || out_ready).
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_word` unchanged.
- R7: The alignment word is [63:58] = 6'h1E, [57:0] = 0, header 2'b10. `out_sof` is 1 exactly while the output holds an alignment word.
- R8: The diagnostic word is [63:58] = 6'h19, [33:32] = `diag_status` as sampled when the word is loaded, and all other data bits 0. Its header is 2'b10.
- R9: Between two consecutive alignment-word transfers there are exactly FRAME_LEN word transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Block accepts a payload word this cycle |
| in_data | input | 64 | Payload data |
| in_ctl | input | 1 | Payload control flag |
| diag_status | input | 2 | Lane status placed in the diagnostic word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_word | output | 67 | Framed word: inversion bit, header, data |
| out_sof | output | 1 | Marks the alignment word that starts a metaframe |

## Verification
Two things can fall in the same cycle: the frame position stepping from a payload slot into a control slot, and a downstream stall or an idle input. If the stall is mishandled, a payload word is taken into a control slot, or the frame order slips. Random `out_ready` and `in_valid` patterns, together with runs at full rate, place stalls on every slot boundary, including the single payload slot of the minimum frame length. A behavioural model is compared on every clock against `out_valid`, `out_word`, `out_sof` and `in_ready`. It is backed by an independent check of stall stability and of the frame length.

// File: rtl/mframe_pkg.sv
`timescale 1ns/1ps
package mframe_pkg;
  localparam int DATA_W = 64;
  localparam int HDR_W  = 2;
  localparam int WORD_W = DATA_W + HDR_W + 1;
  localparam int TYPE_W = 6;
  localparam int STAT_W = 2;
  localparam int STAT_LSB = 32;

  typedef enum logic [2:0] {
    SLOT_SYNC, SLOT_SCRST, SLOT_SKIP, SLOT_DATA, SLOT_DIAG
  } slot_e;

  localparam logic [HDR_W-1:0]  HDR_CTRL   = 2'b10;
  localparam logic [HDR_W-1:0]  HDR_DATA   = 2'b01;
  localparam logic [TYPE_W-1:0] TYPE_SYNC  = 6'h1E;
  localparam logic [TYPE_W-1:0] TYPE_SCRST = 6'h0A;
  localparam logic [TYPE_W-1:0] TYPE_SKIP  = 6'h07;
  localparam logic [TYPE_W-1:0] TYPE_DIAG  = 6'h19;

  function automatic logic [WORD_W-1:0] pack_word(input logic [HDR_W-1:0] hdr,
                                                   input logic [DATA_W-1:0] d);
    return {1'b0, hdr, d};
  endfunction
endpackage

// File: rtl/mframe_slot_ctr.sv
`timescale 1ns/1ps
module mframe_slot_ctr
  import mframe_pkg::*;
#(
  parameter int FRAME_LEN = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  output slot_e slot
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos_q <= '0;
    else if (advance) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  always_comb begin
    if (pos_q == CW'(0))      slot = SLOT_SYNC;
    else if (pos_q == CW'(1)) slot = SLOT_SCRST;
    else if (pos_q == CW'(2)) slot = SLOT_SKIP;
    else if (pos_q == LAST)   slot = SLOT_DIAG;
    else                      slot = SLOT_DATA;
  end

  AST_WRAP_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    advance && slot == SLOT_DIAG |=> slot == SLOT_SYNC); // R2
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST); // R9
endmodule

// File: rtl/mframe_ctl_gen.sv
`timescale 1ns/1ps
module mframe_ctl_gen
  import mframe_pkg::*;
(
  input  slot_e              slot,
  input  logic [STAT_W-1:0]  diag_status,
  output logic [DATA_W-1:0]  ctl_data
);
  always_comb begin
    ctl_data = '0;
    case (slot)
      SLOT_SYNC:  ctl_data[DATA_W-1 -: TYPE_W] = TYPE_SYNC;
      SLOT_SCRST: ctl_data[DATA_W-1 -: TYPE_W] = TYPE_SCRST;
      SLOT_SKIP:  ctl_data[DATA_W-1 -: TYPE_W] = TYPE_SKIP;
      SLOT_DIAG: begin
        ctl_data[DATA_W-1 -: TYPE_W]     = TYPE_DIAG;
        ctl_data[STAT_LSB +: STAT_W]     = diag_status;
      end
      default:    ctl_data = '0;
    endcase
  end
endmodule

// File: rtl/mframe_out_stage.sv
`timescale 1ns/1ps
module mframe_out_stage
  import mframe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              load_sof,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_sof,
  output logic              can_load
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_sof   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= load_word;
      out_sof   <= load_sof;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R6
  AST_INV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_word[WORD_W-1]); // R3
endmodule

// File: rtl/mframe_framer.sv
`timescale 1ns/1ps
module mframe_framer
  import mframe_pkg::*;
#(
  parameter int FRAME_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ctl,
  input  logic [STAT_W-1:0] diag_status,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_sof
);
  slot_e             slot;
  logic [DATA_W-1:0] ctl_data;
  logic              is_ctrl;
  logic              can_load;
  logic              load;
  logic [WORD_W-1:0] load_word;

  mframe_slot_ctr #(.FRAME_LEN(FRAME_LEN)) u_slot (
    .clk(clk), .rst_n(rst_n), .advance(load), .slot(slot)
  );

  mframe_ctl_gen u_ctl (
    .slot(slot), .diag_status(diag_status), .ctl_data(ctl_data)
  );

  assign is_ctrl   = (slot != SLOT_DATA);
  assign in_ready  = !is_ctrl && can_load;
  assign load      = can_load && (is_ctrl || in_valid);
  assign load_word = is_ctrl ? pack_word(HDR_CTRL, ctl_data)
                             : pack_word(in_ctl ? HDR_CTRL : HDR_DATA, in_data);

  mframe_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
    .load_sof(slot == SLOT_SYNC), .out_ready(out_ready),
    .out_valid(out_valid), .out_word(out_word), .out_sof(out_sof),
    .can_load(can_load)
  );

  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_word[DATA_W-1:0] == $past(in_data)
      && out_word[DATA_W +: HDR_W] == ($past(in_ctl) ? HDR_CTRL : HDR_DATA)); // R4
  AST_SOF_IS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_word[DATA_W +: HDR_W] == HDR_CTRL
      && out_word[DATA_W-1 -: TYPE_W] == TYPE_SYNC); // R7
  AST_SCRST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_sof |=> out_valid
      && out_word[DATA_W-1 -: TYPE_W] == TYPE_SCRST); // R2
endmodule

// File: tb/mframe_framer_tb_top.sv
`timescale 1ns/1ps
module mframe_framer_tb_top;
  localparam int LEN = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_ctl = 1'b0;
  logic [1:0]  diag_status = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [66:0] out_word;
  logic        out_sof;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mframe_framer #(.FRAME_LEN(LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctl(in_ctl), .diag_status(diag_status),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_sof(out_sof)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference state.
  bit          mv;
  bit          msof;
  logic [66:0] mw;
  int          mpos;
  string       mtag;
  bit          prev_stall;
  logic [66:0] prev_word;
  int          xfer_cnt;
  bit          seen_sof;

  function automatic bit slot_is_data(input int p);
    return (p >= 3) && (p < LEN - 1);
  endfunction

  function automatic logic [66:0] ctrl_word(input int p, input logic [1:0] st);
    logic [63:0] d;
    d = '0;
    if (p == 0)            d[63:58] = 6'h1E;
    else if (p == 1)       d[63:58] = 6'h0A;
    else if (p == 2)       d[63:58] = 6'h07;
    else begin
      d[63:58] = 6'h19;
      d[33:32] = st;
    end
    return {1'b0, 2'b10, d};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mv = 0; msof = 0; mpos = 0; mw = '0; xfer_cnt = 0; seen_sof = 0;
    end else begin
      if (out_valid && out_ready) begin
        if (out_sof) begin
          if (seen_sof) chk(xfer_cnt == LEN, "R9 frame length", 67'(xfer_cnt), 67'(LEN));
          seen_sof = 1; xfer_cnt = 0;
        end
        xfer_cnt++;
      end
      if (!mv || out_ready) begin
        if (!slot_is_data(mpos)) begin
          mw = ctrl_word(mpos, diag_status);
          msof = (mpos == 0);
          mtag = (mpos == 0) ? "R7 sync word" : (mpos == LEN - 1) ? "R8 diag word" : "R3 ctrl word";
          mv = 1; mpos = (mpos + 1) % LEN;
        end else if (in_valid) begin
          mw = {1'b0, in_ctl ? 2'b10 : 2'b01, in_data};
          msof = 0; mtag = "R4 payload word";
          mv = 1; mpos = (mpos + 1) % LEN;
        end else begin
          mv = 0; msof = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_valid == 1'b0, "R1 valid in reset", 67'(out_valid), 67'(0));
      prev_stall = 0;
    end else if (!done) begin
      if (prev_stall)
        chk(out_valid && out_word == prev_word, "R6 stall hold", out_word, prev_word);
      chk(out_valid == mv, "R2 valid order", 67'(out_valid), 67'(mv));
      if (mv) begin
        chk(out_word == mw, mtag, out_word, mw);
        chk(out_sof == msof, "R7 sof", 67'(out_sof), 67'(msof));
      end
      chk(in_ready == (slot_is_data(mpos) && (!mv || out_ready)), "R5 in_ready",
          67'(in_ready), 67'(slot_is_data(mpos) && (!mv || out_ready)));
      prev_stall = out_valid && !out_ready;
      prev_word  = out_word;
    end
  end

  task automatic drive(input int cycles, input int pv, input int pr);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      in_valid    = ($urandom_range(99) < pv);
      out_ready   = ($urandom_range(99) < pr);
      in_data     = {$urandom, $urandom};
      in_ctl      = ($urandom_range(3) == 0);
      diag_status = 2'($urandom_range(3));
    end
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R1: first cycle after reset release must show no valid word
    rst_n = 1'b1;
    @(negedge clk);
    drive(300, 100, 100);   // full rate
    drive(600, 40, 100);    // sparse input
    drive(600, 100, 35);    // downstream stalls
    drive(1500, 55, 55);    // both random
    drive(200, 0, 100);     // idle input, control words still flow
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule